// File: doc/BRIEF.md
# Mantissa-Exponent Normalizer

This block turns a 32-bit integer into a packed mantissa/exponent word. The operand is shifted left so that its significant bits move to the top. The upper 24 bits of the shifted value become the mantissa in the top of the result. The low 8 bits carry the negated shift count, kept modulo 256.

The shift count depends on a 2-bit mode:
- **Unsigned mode** shifts out every leading zero.
- **Signed mode** keeps exactly one copy of the sign bit.
  - A negative operand is shifted by its leading-one count minus one.
  - A non-negative operand is shifted by its leading-zero count minus one.
- **Even mode** uses the leading-zero count rounded down to an even number, so the exponent always stays even.

A caller presents the operand with a valid strobe. The packed word and a matching valid flag appear one clock later. The result holds between strobes.

Top module: `norm_unit`

## Requirements
- R1: The result is packed with the top 24 bits of the shifted operand in result[31:8] and the exponent in result[7:0]; the exponent is the shift count negated and truncated to 8 bits.
- R2: With mode = 0 (unsigned) the operand is shifted left by its leading-zero count.
- R3: With mode = 1 (signed) and operand bit 31 set, the shift is the leading-one count minus one.
- R4: With mode = 1 and operand bit 31 clear, the shift is the leading-zero count minus one.
- R5: With mode = 2 (even) the shift is the leading-zero count with its lowest bit cleared, so the exponent is always even.
- R6: An all-zero operand in unsigned or even mode gives result 0x000000E0 (shift 32, empty mantissa).
- R7: In signed mode, operand 0 gives 0x000000E1 and operand 0xFFFFFFFF gives 0x800000E1 (both use a shift of 31).
- R8: outValid is high exactly in the cycle after a cycle with inValid high, and result holds the value for that operand in the same cycle.
- R9: While inValid is low, result keeps its previous value and outValid is low in the following cycle, whatever operand and mode are applied.
- R10: A synchronous active-high reset clears result to 0 and outValid to 0.
- R11: mode = 3 behaves exactly like unsigned mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand and mode are valid this cycle |
| operand | input | 32 | Integer to normalize |
| mode | input | 2 | 0 unsigned, 1 signed, 2 even, 3 as unsigned |
| outValid | output | 1 | Result valid (one cycle after inValid) |
| result | output | 32 | {mantissa[23:0], exponent[7:0]} |

## Verification
The bench targets the count extremes and the mode-specific corners:
- **Zero operands.** A design that caps the count at 31, or that wraps the shift, would return a nonzero mantissa or exponent 0xE1 instead of 0xE0.
- **Signed-mode edge values.** The bench applies 0, all-ones, 0x40000000 and 0xBFFFFFFF. A design that forgets the minus-one shift would lose the sign bit. A design that counts ones on the wrong polarity would shift a negative value by its zero count.
- **Odd leading-zero counts in even mode.** A design that rounds up instead of down would push a set bit off the top.
- **Mode 3.** A design that does not treat mode 3 as unsigned would produce a different result for the same operand.
- **Idle cycles with changing inputs.** These expose a result register that loads without the strobe.

// File: rtl/norm_pkg.sv
package norm_pkg;
  typedef enum logic [1:0] {
    MODE_UNS  = 2'd0,
    MODE_SGN  = 2'd1,
    MODE_EVEN = 2'd2,
    MODE_ALT  = 2'd3
  } norm_mode_t;

  typedef struct packed {
    logic load;
    logic clear;
  } norm_strobe_t;
endpackage

// File: rtl/norm_lzc.sv
module norm_lzc #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  // Highest set bit wins: scanning upward overwrites lower hits.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/norm_ctrl.sv
module norm_ctrl
  import norm_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output norm_strobe_t strobe,
  output logic         outValid
);
  always_comb begin
    strobe.load  = inValid & ~rst;
    strobe.clear = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_no_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  assert_reset_clears_valid_R10: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

// File: rtl/norm_datapath.sv
module norm_datapath
  import norm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8,
  localparam int SHIFT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  norm_strobe_t      strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] result
);
  logic [SHIFT_W-1:0] zeroCnt;
  logic [SHIFT_W-1:0] oneCnt;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [DATA_W-1:0]  shifted;
  logic [EXP_W-1:0]   expo;
  norm_mode_t         modeSel;

  norm_lzc #(.W(DATA_W)) zeroCounter_i (.vec(operand),  .count(zeroCnt));
  norm_lzc #(.W(DATA_W)) oneCounter_i  (.vec(~operand), .count(oneCnt));

  always_comb begin
    modeSel = norm_mode_t'(mode);
    unique case (modeSel)
      MODE_SGN:  shiftAmt = operand[DATA_W-1] ? (oneCnt - 1'b1) : (zeroCnt - 1'b1);
      MODE_EVEN: shiftAmt = {zeroCnt[SHIFT_W-1:1], 1'b0};
      default:   shiftAmt = zeroCnt;
    endcase
    shifted = operand << shiftAmt;
    expo    = '0 - EXP_W'(shiftAmt);
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     result <= '0;
    else if (strobe.load) result <= {shifted[DATA_W-1:EXP_W], expo};
  end

  assert_unsigned_msb_set_R2: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.load && (mode == MODE_UNS || mode == MODE_ALT) && operand != '0)
      |=> result[DATA_W-1]);
  assert_signed_one_sign_bit_R3: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.load && mode == MODE_SGN && operand != '0 && operand != '1)
      |=> (result[DATA_W-1] != result[DATA_W-2]));
  assert_even_exponent_R5: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.load && mode == MODE_EVEN) |=> !result[0]);
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.load |=> $stable(result));
  assert_reset_clears_result_R10: assert property (@(posedge clk)
    strobe.clear |=> (result == '0));
endmodule

// File: rtl/norm_unit.sv
module norm_unit
  import norm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        mode,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  norm_strobe_t strobe;

  norm_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .strobe(strobe), .outValid(outValid)
  );

  norm_datapath #(.DATA_W(DATA_W), .EXP_W(EXP_W)) datapath_i (
    .clk(clk), .strobe(strobe), .operand(operand), .mode(mode), .result(result)
  );
endmodule

// File: tb/norm_unit_tb_top.sv
module norm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [31:0] operand;
  logic [1:0]  mode;
  logic        outValid;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  norm_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .operand(operand),
    .mode(mode), .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] refModel(logic [31:0] x, logic [1:0] m);
    int zc = 32;
    int oc = 32;
    int sh;
    logic [31:0] s;
    logic [7:0]  e;
    for (int i = 0; i < 32; i++) begin
      if (x[i])  zc = 31 - i;
      if (!x[i]) oc = 31 - i;
    end
    if (m == 2'd1)      sh = x[31] ? oc - 1 : zc - 1;
    else if (m == 2'd2) sh = zc - (zc % 2);
    else                sh = zc;
    s = (sh >= 32) ? 32'h0 : (x << sh);
    e = 8'(256 - sh);
    return {s[31:8], e};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] x, logic [1:0] m, string tag);
    @(negedge clk);
    inValid = 1'b1; operand = x; mode = m;
    expQ.push_back(refModel(x, m));
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: compare each valid output against the oldest expected item.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && outValid) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8: unexpected outValid, actual=%h expected=none", result);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, result, e);
        end
      end
    end
  end

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] held;
    rst = 1'b1; inValid = 1'b0; operand = 32'h0; mode = 2'd0;
    repeat (3) @(negedge clk);
    check("R10 result after reset", result, 32'h0);
    check("R10 outValid after reset", {31'h0, outValid}, 32'h0);
    rst = 1'b0;

    drive(32'h0000_0001, 2'd0, "R2 unsigned lsb");
    drive(32'h0012_3456, 2'd0, "R2 unsigned mid");
    drive(32'h8000_0000, 2'd0, "R1 unsigned no shift");
    drive(32'h0000_0000, 2'd0, "R6 unsigned zero");
    drive(32'h0000_0000, 2'd2, "R6 even zero");
    drive(32'h0000_0000, 2'd1, "R7 signed zero");
    drive(32'hFFFF_FFFF, 2'd1, "R7 signed all-ones");
    drive(32'hFFFF_F000, 2'd1, "R3 signed negative");
    drive(32'hBFFF_FFFF, 2'd1, "R3 signed negative edge");
    drive(32'h4000_0000, 2'd1, "R4 signed positive edge");
    drive(32'h0000_00FF, 2'd1, "R4 signed positive");
    drive(32'h1000_0000, 2'd2, "R5 even odd count");
    drive(32'h0000_0100, 2'd2, "R5 even count 23");
    drive(32'h2000_0000, 2'd2, "R5 even count 2");
    drive(32'h0012_3456, 2'd3, "R11 alt mode");
    drive(32'h0000_0000, 2'd3, "R11 alt zero");
    idle();
    @(negedge clk);
    check("R1 direct pack", refModel(32'h0000_0001, 2'd0), 32'h8000_00E1);

    // Hold: strobe low with changing inputs must not touch the result.
    drive(32'h0000_0F00, 2'd0, "R8 before hold");
    idle();
    @(negedge clk);
    held = result;
    operand = 32'h0000_0003; mode = 2'd1;
    @(negedge clk);
    check("R9 result held", result, held);
    check("R9 outValid low", {31'h0, outValid}, 32'h0);
    operand = 32'h7777_0000; mode = 2'd2;
    @(negedge clk);
    check("R9 result held again", result, held);

    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr >> (i % 32), 2'(i % 4), "R1 sweep");
      if (i % 7 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    check("R8 queue drained", 32'(expQ.size()), 32'h0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 result after mid reset", result, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule